// File: doc/BRIEF.md
# Length-Prefixed Frame Capture Engine

This block sits behind a chip-select-framed serial receiver. It watches the received byte stream and captures one frame into a local byte buffer. The frame opens with a two-byte length header, high byte first. The engine writes both header bytes and the payload into the buffer through a byte write port. When the last byte has been written, it raises a done flag. If a frame will not fit in the buffer, the engine stores none of it and ignores the rest of the stream until chip select is released.

Each decoded header moves the buffer start offset one step through 0, 1, 2 and then wraps. Successive frames therefore land at different byte alignments, so consumers that copy the buffer are tested at every alignment. The captured total length stays on an output for the consumer. A chip-select release pulse rearms the engine for the next frame. A release that arrives in the middle of a frame throws away the partial frame.

Top module: `fcap_engine`

## Requirements
- R1: A synchronous active-high reset leaves the engine waiting for a header with start offset 0. In the cycle after reset, `wr_en` and `frame_done` are low and `frame_len` is 0.
- R2: The first received byte is bits 15:8 of the payload length and the second byte is bits 7:0. `frame_len` shows payload length + 2 once the frame is accepted, and it holds that value while `frame_done` is high.
- R3: For an accepted frame, every byte, starting with the header high byte, is written in arrival order to consecutive addresses beginning at the start offset. Each byte is written exactly once.
- R4: Each decoded header first advances the start offset (0→1→2→0) and then uses the new value, so the first frame after reset starts at address 1. A header that was only partly received does not advance it.
- R5: A frame whose start offset + total length is greater than BUF_DEPTH (1100) produces no writes and never raises `frame_done`. The engine ignores all further bytes until a release. A frame where start offset + total equals BUF_DEPTH exactly is accepted.
- R6: `frame_done` rises in the same cycle as the write of the final byte. It then stays high, and later bytes cause no writes, until a release.
- R7: A `cs_release` pulse while finished returns the engine to waiting for a header, and `frame_done` is low in the next cycle.
- R8: A `cs_release` pulse while a frame is being received abandons it. No further byte of that frame is written, `frame_done` stays low, and the next two bytes are decoded as a new header.
- R9: A `cs_release` pulse after only one header byte discards that byte. The next two bytes form the header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | A received byte is present on `byte_data` this cycle |
| byte_data | input | 8 | Received byte |
| cs_release | input | 1 | One-cycle pulse when chip select is released; takes priority over a byte in the same cycle |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | ADDR_W (11) | Buffer byte address |
| wr_data | output | 8 | Buffer write byte |
| frame_done | output | 1 | An accepted frame has been fully written |
| frame_len | output | 17 | Total length (payload + 2) of the last accepted frame |

## Verification
The bench targets the edges of the fit rule. At start offset 1, a total of 1100 must be rejected, and at start offset 2, a total of 1098 must be accepted and reach address 1099. An off-by-one comparison would either take a frame that runs off the buffer or refuse one that fits. The bench also covers zero-length payloads, payloads with idle gaps between bytes, bytes that arrive after completion, releases during the header and during the payload, and a reset in mid-header. A design that forgets the pending last byte, writes the byte that follows an abandoned frame, or moves the offset on a partial header would show up as a missing, extra or misplaced write in the scoreboard.

// File: rtl/fcap_pkg.sv
`timescale 1ns/1ps
package fcap_pkg;
    localparam int BYTE_W = 8;
    localparam int PAY_W  = 16;
    localparam int TOT_W  = PAY_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RECV = 2'd1,
        ST_DONE = 2'd2
    } cap_state_e;
endpackage

// File: rtl/fcap_align_rot.sv
`timescale 1ns/1ps
module fcap_align_rot #(
    parameter int SPAN   = 3,
    parameter int BASE_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    output logic [BASE_W-1:0] base_q,
    output logic [BASE_W-1:0] base_nx
);
    generate
        if (SPAN > 1) begin : g_rot
            logic [BASE_W-1:0] cur_d, cur_q;
            assign base_nx = (cur_q == BASE_W'(SPAN - 1)) ? '0 : cur_q + 1'b1;
            always_comb begin
                cur_d = cur_q;
                if (advance) cur_d = base_nx;
            end
            always_ff @(posedge clk) begin
                if (rst) cur_q <= '0;
                else     cur_q <= cur_d;
            end
            assign base_q = cur_q;
        end else begin : g_fixed
            assign base_q  = '0;
            assign base_nx = '0;
        end
    endgenerate
endmodule

// File: rtl/fcap_hdr_fit.sv
`timescale 1ns/1ps
module fcap_hdr_fit
    import fcap_pkg::*;
#(
    parameter int BUF_DEPTH = 1100,
    parameter int BASE_W    = 2
) (
    input  logic [BYTE_W-1:0] len_hi,
    input  logic [BYTE_W-1:0] len_lo,
    input  logic [BASE_W-1:0] base,
    output logic [PAY_W-1:0]  pay_len,
    output logic [TOT_W-1:0]  tot_len,
    output logic              fits
);
    localparam int SUM_W = TOT_W + 1;
    localparam logic [SUM_W-1:0] DEPTH_V = SUM_W'(BUF_DEPTH);

    logic [SUM_W-1:0] end_pos;

    always_comb begin
        pay_len = {len_hi, len_lo};
        tot_len = TOT_W'(pay_len) + TOT_W'(2);
        end_pos = SUM_W'(tot_len) + SUM_W'(base);
        fits    = (end_pos <= DEPTH_V);
    end
endmodule

// File: rtl/fcap_engine.sv
`timescale 1ns/1ps
module fcap_engine
    import fcap_pkg::*;
#(
    parameter int BUF_DEPTH  = 1100,
    parameter int ALIGN_SPAN = 3,
    parameter int ADDR_W     = $clog2(BUF_DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 byte_vld,
    input  logic [7:0]           byte_data,
    input  logic                 cs_release,
    output logic                 wr_en,
    output logic [ADDR_W-1:0]    wr_addr,
    output logic [7:0]           wr_data,
    output logic                 frame_done,
    output logic [16:0]          frame_len
);
    localparam int BASE_W = (ALIGN_SPAN > 1) ? $clog2(ALIGN_SPAN) : 1;

    typedef struct packed {
        cap_state_e          st;
        logic                hdr_have;
        logic [BYTE_W-1:0]   hdr_hi;
        logic [PAY_W-1:0]    remain;
        logic [ADDR_W-1:0]   idx;
        logic [BYTE_W-1:0]   held;
        logic                held_v;
        logic                accepted;
        logic [TOT_W-1:0]    len;
        logic                wr_en;
        logic [ADDR_W-1:0]   wr_addr;
        logic [BYTE_W-1:0]   wr_data;
    } cap_regs_t;

    cap_regs_t         r_d, r_q;
    logic              rot_adv;
    logic [BASE_W-1:0] base_q, base_nx;
    logic [PAY_W-1:0]  pay_len;
    logic [TOT_W-1:0]  tot_len;
    logic              hdr_fits;
    logic [ADDR_W-1:0] cur_addr;

    fcap_align_rot #(
        .SPAN   (ALIGN_SPAN),
        .BASE_W (BASE_W)
    ) u_rot (
        .clk     (clk),
        .rst     (rst),
        .advance (rot_adv),
        .base_q  (base_q),
        .base_nx (base_nx)
    );

    fcap_hdr_fit #(
        .BUF_DEPTH (BUF_DEPTH),
        .BASE_W    (BASE_W)
    ) u_fit (
        .len_hi  (r_q.hdr_hi),
        .len_lo  (byte_data),
        .base    (base_nx),
        .pay_len (pay_len),
        .tot_len (tot_len),
        .fits    (hdr_fits)
    );

    assign cur_addr = ADDR_W'(base_q) + r_q.idx;

    always_comb begin
        r_d       = r_q;
        r_d.wr_en = 1'b0;
        rot_adv   = 1'b0;

        // pending final byte of a completed frame goes out first
        if (r_q.st == ST_DONE && r_q.held_v) begin
            r_d.wr_en   = 1'b1;
            r_d.wr_addr = cur_addr;
            r_d.wr_data = r_q.held;
            r_d.held_v  = 1'b0;
            r_d.idx     = r_q.idx + 1'b1;
        end

        if (cs_release) begin
            r_d.st       = ST_IDLE;
            r_d.hdr_have = 1'b0;
            r_d.held_v   = 1'b0;
            r_d.accepted = 1'b0;
        end else if (byte_vld) begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (!r_q.hdr_have) begin
                        r_d.hdr_have = 1'b1;
                        r_d.hdr_hi   = byte_data;
                    end else begin
                        r_d.hdr_have = 1'b0;
                        rot_adv      = 1'b1;
                        if (hdr_fits) begin
                            r_d.wr_en    = 1'b1;
                            r_d.wr_addr  = ADDR_W'(base_nx);
                            r_d.wr_data  = r_q.hdr_hi;
                            r_d.held     = byte_data;
                            r_d.held_v   = 1'b1;
                            r_d.idx      = ADDR_W'(1);
                            r_d.remain   = pay_len;
                            r_d.len      = tot_len;
                            r_d.accepted = 1'b1;
                            r_d.st       = (pay_len == '0) ? ST_DONE : ST_RECV;
                        end else begin
                            r_d.accepted = 1'b0;
                            r_d.st       = ST_DONE;
                        end
                    end
                end
                ST_RECV: begin
                    r_d.wr_en   = 1'b1;
                    r_d.wr_addr = cur_addr;
                    r_d.wr_data = r_q.held;
                    r_d.held    = byte_data;
                    r_d.idx     = r_q.idx + 1'b1;
                    r_d.remain  = r_q.remain - 1'b1;
                    if (r_q.remain == PAY_W'(1)) r_d.st = ST_DONE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign wr_en      = r_q.wr_en;
    assign wr_addr    = r_q.wr_addr;
    assign wr_data    = r_q.wr_data;
    assign frame_len  = r_q.len;
    assign frame_done = (r_q.st == ST_DONE) && r_q.accepted && !r_q.held_v;
endmodule

// File: rtl/fcap_engine_chk.sv
`timescale 1ns/1ps
module fcap_engine_chk #(
    parameter int BUF_DEPTH = 1100,
    parameter int ADDR_W    = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_release,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              frame_done,
    input logic [16:0]       frame_len
);
    AST_RST_QUIET: assert property (@(posedge clk)
        rst |=> (!wr_en && !frame_done)); // R1

    AST_LEN_HELD: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> $stable(frame_len)); // R2

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en)) |-> (wr_addr == ADDR_W'($past(wr_addr) + 1'b1))); // R3

    AST_ADDR_IN_BUF: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(wr_addr) < BUF_DEPTH)); // R5

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !cs_release) |=> !wr_en); // R6

    AST_RELEASE_DROPS: assert property (@(posedge clk) disable iff (rst)
        cs_release |=> !frame_done); // R7
endmodule

bind fcap_engine fcap_engine_chk #(
    .BUF_DEPTH (BUF_DEPTH),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_release (cs_release),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .frame_done (frame_done),
    .frame_len  (frame_len)
);

// File: tb/fcap_engine_test.sv
`timescale 1ns/1ps
module fcap_engine_test;
    localparam int DEPTH = 1100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic        cs_release = 1'b0;
    logic        wr_en;
    logic [10:0] wr_addr;
    logic [7:0]  wr_data;
    logic        frame_done;
    logic [16:0] frame_len;

    int n_chk = 0;
    int n_bad = 0;
    int exp_addr[$];
    int exp_data[$];
    int base_m = 0;

    fcap_engine uut (
        .clk        (clk),
        .rst        (rst),
        .byte_vld   (byte_vld),
        .byte_data  (byte_data),
        .cs_release (cs_release),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .frame_done (frame_done),
        .frame_len  (frame_len)
    );

    always #2 clk = ~clk;

    task automatic chk(input int act, input int exp, input string req);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        int ea;
        int ed;
        if (!rst && wr_en) begin
            n_chk++;
            if (exp_addr.size() == 0) begin
                n_bad++;
                $display("FAIL R5 R6 R8 unexpected write actual=%0d:%0d expected=none",
                         wr_addr, wr_data);
            end else begin
                ea = exp_addr.pop_front();
                ed = exp_data.pop_front();
                if (int'(wr_addr) != ea || int'(wr_data) != ed) begin
                    n_bad++;
                    $display("FAIL R3 R4 write actual=%0d:%0d expected=%0d:%0d",
                             wr_addr, wr_data, ea, ed);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input int b);
        byte_vld  = 1'b1;
        byte_data = 8'(b);
        @(negedge clk);
        byte_vld  = 1'b0;
    endtask

    task automatic release_cs();
        cs_release = 1'b1;
        @(negedge clk);
        cs_release = 1'b0;
    endtask

    function automatic int pay_byte(input int plen, input int k);
        return (k * 7 + plen + 3) & 255;
    endfunction

    // driver: pushes expected writes then sends header + nsend payload bytes
    task automatic run_frame(input int plen, input int nsend, input int gap);
        int total;
        int nb;
        int nw;
        bit ok;
        int b;
        base_m = (base_m + 1) % 3;
        total  = plen + 2;
        ok     = (base_m + total) <= DEPTH;
        nb     = 2 + nsend;
        nw     = (nsend >= plen) ? nb : nb - 1;
        if (ok) begin
            for (int i = 0; i < nw; i++) begin
                if (i == 0)      b = (plen >> 8) & 255;
                else if (i == 1) b = plen & 255;
                else             b = pay_byte(plen, i - 2);
                exp_addr.push_back(base_m + i);
                exp_data.push_back(b);
            end
        end
        send((plen >> 8) & 255);
        send(plen & 255);
        for (int k = 0; k < nsend; k++) begin
            send(pay_byte(plen, k));
            if (gap > 0) tick(gap);
        end
    endtask

    task automatic drained(input string req);
        tick(3);
        chk(exp_addr.size(), 0, req);
    endtask

    initial begin
        tick(3);
        chk(int'(wr_en), 0, "R1 wr_en in reset");
        rst = 1'b0;
        tick(1);
        chk(int'(wr_en), 0, "R1 wr_en after reset");
        chk(int'(frame_done), 0, "R1 frame_done after reset");
        chk(int'(frame_len), 0, "R1 frame_len after reset");

        // short frame at offset 1
        run_frame(3, 3, 0);
        drained("R3 R4 frame 3 writes");
        chk(int'(frame_done), 1, "R6 done after frame 3");
        chk(int'(frame_len), 5, "R2 len frame 3");
        for (int k = 0; k < 4; k++) send(8'h5A + k);
        drained("R6 trailing bytes ignored");
        chk(int'(frame_done), 1, "R6 done held");
        release_cs();
        chk(int'(frame_done), 0, "R7 release clears done");

        // empty payload at offset 2
        run_frame(0, 0, 0);
        drained("R3 empty payload writes");
        chk(int'(frame_done), 1, "R6 done empty payload");
        chk(int'(frame_len), 2, "R2 len empty payload");
        release_cs();

        // gapped payload at offset 0
        run_frame(4, 4, 2);
        drained("R3 R4 gapped writes");
        chk(int'(frame_done), 1, "R6 done gapped");
        chk(int'(frame_len), 6, "R2 len gapped");
        release_cs();

        // oversize: offset 1, total 1100
        run_frame(1098, 5, 0);
        drained("R5 oversize no writes");
        chk(int'(frame_done), 0, "R5 oversize no done");
        chk(int'(frame_len), 6, "R5 len unchanged");
        release_cs();

        // exact fit: offset 2, total 1098 reaches address 1099
        run_frame(1096, 1096, 0);
        drained("R5 exact fit writes");
        chk(int'(frame_done), 1, "R5 exact fit done");
        chk(int'(frame_len), 1098, "R2 R5 len exact fit");
        release_cs();

        // abandon mid-payload at offset 0
        run_frame(5, 3, 0);
        release_cs();
        drained("R8 abandoned writes");
        chk(int'(frame_done), 0, "R8 no done after abandon");
        run_frame(2, 2, 0);
        drained("R8 next header after abandon");
        chk(int'(frame_done), 1, "R8 done next frame");
        chk(int'(frame_len), 4, "R8 len next frame");
        release_cs();

        // release after one header byte
        send(8'hAB);
        release_cs();
        run_frame(1, 1, 0);
        drained("R9 R4 header restart writes");
        chk(int'(frame_done), 1, "R9 done after restart");
        chk(int'(frame_len), 3, "R9 len after restart");
        release_cs();

        // reset in mid-header
        send(8'h00);
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
        base_m = 0;
        tick(1);
        chk(int'(frame_done), 0, "R1 done after mid reset");
        chk(int'(frame_len), 0, "R1 len after mid reset");
        run_frame(2, 2, 0);
        drained("R1 R4 offset after mid reset");
        chk(int'(frame_done), 1, "R1 done after mid reset frame");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_chk++;
        n_bad++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule